// File: doc/BRIEF.md
# Serial Configuration-Store Slave

This block is a two-wire serial bus slave that fronts a 256 x 8 configuration store of the kind fitted to a plug-in memory module so that a host can find out what the module is. A host addresses the slave with the fixed device type `1010` and three strap pins. It can then set the internal byte pointer and write one or more bytes, or set the pointer and read back any number of bytes in sequence. The pointer advances after every byte and wraps from the last location to zero.

The store has two halves. The lower half holds the descriptor written by whoever builds the module. A write-protect pin guards it, and a protected write is still acknowledged on the bus. The upper half is always free for the end user. A status output compares the checksum byte at offset 63 with the low eight bits of the sum of bytes 0 to 62. A preload port lets the surrounding logic place any byte at any location, for example to load the descriptor when the system starts. The bus pins are sampled with the block's own clock, which must run several times faster than SCL. SDA is driven as an open-drain output through a pull-low enable.

Top module: `spd_prom_slave`

## Requirements
- R1: The slave acknowledges a device address byte only when its upper seven bits equal `1010` followed by strap bits 2, 1, 0. The lowest bit selects read (1) or write (0). On any other address the slave leaves SDA released and ignores the bus until the next START.
- R2: After reset the store holds 0x80 at byte 0, 0x08 at byte 1, the checksum of bytes 0 to 62 (0x4B) at byte 63, and 0xFF everywhere else. In the idle state SDA is never pulled low.
- R3: In a write transfer the first byte after the device address loads the pointer. Every later byte is stored at the pointer, and the pointer then advances by one.
- R4: While write-protect is high, a bus write to bytes 0 to 127 is acknowledged but leaves the store unchanged. While write-protect is low, such a write takes effect.
- R5: Bus writes to bytes 128 to 255 take effect whatever the write-protect level.
- R6: A read transfer returns the byte at the pointer, most significant bit first, and advances the pointer after each byte. The pointer wraps from 255 to 0.
- R7: `csum_ok` is high exactly when the low 8 bits of the sum of bytes 0 to 62 equal byte 63. It follows every change made by the bus or by preload.
- R8: A START at any point, including in the middle of a byte, abandons the current transfer and begins decoding a new device address.
- R9: A STOP returns the slave to idle. Clock pulses that follow without a START get no acknowledge.
- R10: A preload write stores its byte at any address even while write-protect is high. It takes priority over a bus write in the same cycle.
- R11: When the master does not acknowledge a read byte, the slave releases SDA and drives nothing more until a new START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling and state clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_drive_low | output | 1 | Pull-low enable for the open-drain SDA driver |
| strap_i | input | 3 | Address straps, low three bits of the device address |
| wp_i | input | 1 | Write-protect for the lower half of the store |
| preload_we | input | 1 | Preload write strobe |
| preload_addr | input | 8 | Preload target address |
| preload_data | input | 8 | Preload byte |
| csum_ok | output | 1 | High when byte 63 matches the checksum of bytes 0 to 62 |

## Verification
The corner that is hardest to reach from the ports is a START that lands partway through a byte, while the bit counter is mid-count and the slave is neither acknowledging nor idle. The bench clocks out four address bits and then raises SDA while SCL is low, raises SCL and pulls SDA low. After that a complete random read must still succeed. The pointer wrap is reached with a single long sequential read that starts two bytes below the top. Its values are placed there beforehand, so the third byte read can only be correct if the pointer returned to byte 0.

// File: rtl/spd_prom_pkg.sv
package spd_prom_pkg;

   localparam int BYTE_W = 8;
   localparam logic [3:0] DEV_TYPE = 4'b1010;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEV,
      ST_DEV_ACK,
      ST_WADDR,
      ST_WADDR_ACK,
      ST_WDATA,
      ST_WDATA_ACK,
      ST_RDATA,
      ST_RMACK
   } link_state_t;

   // Factory value of one location, checksum byte excluded
   function automatic logic [BYTE_W-1:0] base_value(int unsigned idx, int unsigned addr_w);
      logic [31:0] t;
      if (idx == 0) begin
         t = 32'd1 << (addr_w - 1);
         return t[BYTE_W-1:0];
      end else if (idx == 1) begin
         t = addr_w;
         return t[BYTE_W-1:0];
      end
      return 8'hFF;
   endfunction

   // Checksum of the factory contents below the checksum location
   function automatic logic [BYTE_W-1:0] base_sum(int unsigned csum_idx, int unsigned addr_w);
      logic [BYTE_W-1:0] acc;
      acc = '0;
      for (int unsigned i = 0; i < csum_idx; i++) acc = acc + base_value(i, addr_w);
      return acc;
   endfunction

endpackage

// File: rtl/spd_prom_sync.sv
module spd_prom_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_q,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic [STAGES-1:0] scl_p;
   logic [STAGES-1:0] sda_p;
   logic              scl_d;
   logic              sda_d;
   logic              scl_s;
   logic              sda_s;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_p[0] <= 1'b1;
               sda_p[0] <= 1'b1;
            end else begin
               scl_p[0] <= scl_i;
               sda_p[0] <= sda_i;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_p[g] <= 1'b1;
               sda_p[g] <= 1'b1;
            end else begin
               scl_p[g] <= scl_p[g-1];
               sda_p[g] <= sda_p[g-1];
            end
         end
      end
   end

   assign scl_s = scl_p[STAGES-1];
   assign sda_s = sda_p[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   assign sda_q     = sda_s;
   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/spd_prom_store.sv
module spd_prom_store
   import spd_prom_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int CSUM_IDX    = 63,
   parameter bit RUNNING_SUM = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [BYTE_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [BYTE_W-1:0] rdata,
   output logic              csum_ok
);

   localparam int                DEPTH     = 1 << ADDR_W;
   localparam logic [ADDR_W-1:0] CSUM_A    = CSUM_IDX[ADDR_W-1:0];
   localparam logic [BYTE_W-1:0] CSUM_INIT = base_sum(CSUM_IDX, ADDR_W);

   logic [BYTE_W-1:0] mem [DEPTH];
   logic [BYTE_W-1:0] sum_now;

   function automatic logic [BYTE_W-1:0] init_byte(int unsigned i);
      return (i == CSUM_IDX) ? CSUM_INIT : base_value(i, ADDR_W);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= init_byte(i);
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   if (RUNNING_SUM) begin : g_running
      // Incremental checksum: one subtract and one add per write
      logic [BYTE_W-1:0] sum_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sum_r <= CSUM_INIT;
         else if (we && (waddr < CSUM_A)) sum_r <= sum_r - mem[waddr] + wdata;
      end
      assign sum_now = sum_r;
   end else begin : g_tree
      // Full recomputation from the stored bytes every cycle
      always_comb begin
         sum_now = '0;
         for (int i = 0; i < CSUM_IDX; i++) sum_now = sum_now + mem[i];
      end
   end

   assign rdata   = mem[raddr];
   assign csum_ok = (sum_now == mem[CSUM_A]);

endmodule

// File: rtl/spd_prom_link.sv
module spd_prom_link
   import spd_prom_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_q,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [2:0]        strap_i,
   input  logic              wp_i,
   input  logic [BYTE_W-1:0] rd_data,
   output logic [ADDR_W-1:0] ptr,
   output logic              wr_req,
   output logic              wr_ok,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [BYTE_W-1:0] wr_data,
   output logic              drive_low,
   output link_state_t       state
);

   localparam int              CNT_W    = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-1:0] shreg;
   logic [BYTE_W-1:0] txreg;
   logic              rnw;
   logic              m_nack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         bit_cnt   <= '0;
         shreg     <= '0;
         txreg     <= '0;
         ptr       <= '0;
         rnw       <= 1'b0;
         m_nack    <= 1'b1;
         drive_low <= 1'b0;
         wr_req    <= 1'b0;
         wr_ok     <= 1'b0;
         wr_addr   <= '0;
         wr_data   <= '0;
      end else begin
         wr_req <= 1'b0;
         if (stop_det) begin
            state     <= ST_IDLE;
            drive_low <= 1'b0;
         end else if (start_det) begin
            state     <= ST_DEV;
            bit_cnt   <= '0;
            drive_low <= 1'b0;
         end else begin
            case (state)
               ST_DEV, ST_WADDR, ST_WDATA: begin
                  if (scl_rise && (bit_cnt != CNT_FULL)) begin
                     shreg   <= {shreg[BYTE_W-2:0], sda_q};
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (scl_fall && (bit_cnt == CNT_FULL)) begin
                     bit_cnt <= '0;
                     if (state == ST_DEV) begin
                        if (shreg[BYTE_W-1:1] == {DEV_TYPE, strap_i}) begin
                           rnw       <= shreg[0];
                           drive_low <= 1'b1;
                           state     <= ST_DEV_ACK;
                        end else begin
                           state <= ST_IDLE;
                        end
                     end else if (state == ST_WADDR) begin
                        ptr       <= shreg[ADDR_W-1:0];
                        drive_low <= 1'b1;
                        state     <= ST_WADDR_ACK;
                     end else begin
                        wr_req    <= 1'b1;
                        wr_ok     <= !(wp_i && !ptr[ADDR_W-1]);
                        wr_addr   <= ptr;
                        wr_data   <= shreg;
                        ptr       <= ptr + 1'b1;
                        drive_low <= 1'b1;
                        state     <= ST_WDATA_ACK;
                     end
                  end
               end
               ST_DEV_ACK: begin
                  if (scl_fall) begin
                     bit_cnt <= '0;
                     if (rnw) begin
                        txreg     <= rd_data;
                        drive_low <= ~rd_data[BYTE_W-1];
                        ptr       <= ptr + 1'b1;
                        state     <= ST_RDATA;
                     end else begin
                        drive_low <= 1'b0;
                        state     <= ST_WADDR;
                     end
                  end
               end
               ST_WADDR_ACK, ST_WDATA_ACK: begin
                  if (scl_fall) begin
                     drive_low <= 1'b0;
                     bit_cnt   <= '0;
                     state     <= ST_WDATA;
                  end
               end
               ST_RDATA: begin
                  if (scl_fall) begin
                     if (bit_cnt == CNT_LAST) begin
                        drive_low <= 1'b0;
                        bit_cnt   <= '0;
                        state     <= ST_RMACK;
                     end else begin
                        txreg     <= {txreg[BYTE_W-2:0], 1'b0};
                        drive_low <= ~txreg[BYTE_W-2];
                        bit_cnt   <= bit_cnt + 1'b1;
                     end
                  end
               end
               ST_RMACK: begin
                  if (scl_rise) m_nack <= sda_q;
                  if (scl_fall) begin
                     if (!m_nack) begin
                        txreg     <= rd_data;
                        drive_low <= ~rd_data[BYTE_W-1];
                        ptr       <= ptr + 1'b1;
                        state     <= ST_RDATA;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               default: begin
                  drive_low <= 1'b0;
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/spd_prom_slave.sv
module spd_prom_slave
   import spd_prom_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int CSUM_IDX    = 63,
   parameter int SYNC_STAGES = 2,
   parameter bit RUNNING_SUM = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_drive_low,
   input  logic [2:0]        strap_i,
   input  logic              wp_i,
   input  logic              preload_we,
   input  logic [ADDR_W-1:0] preload_addr,
   input  logic [BYTE_W-1:0] preload_data,
   output logic              csum_ok
);

   localparam int DEPTH = 1 << ADDR_W;

   initial begin
      if (ADDR_W < 2 || ADDR_W > BYTE_W) $fatal(1, "ADDR_W out of range");
      if (CSUM_IDX < 1 || CSUM_IDX >= DEPTH / 2) $fatal(1, "CSUM_IDX must lie in the lower half");
      if (SYNC_STAGES < 2) $fatal(1, "SYNC_STAGES must be at least 2");
   end

   logic              sda_q;
   logic              scl_rise;
   logic              scl_fall;
   logic              start_det;
   logic              stop_det;
   logic [ADDR_W-1:0] ptr;
   logic              wr_req;
   logic              wr_ok;
   logic [ADDR_W-1:0] wr_addr;
   logic [BYTE_W-1:0] wr_data;
   logic [BYTE_W-1:0] rd_data;
   link_state_t       link_state;
   logic              st_we;
   logic [ADDR_W-1:0] st_addr;
   logic [BYTE_W-1:0] st_data;

   spd_prom_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .sda_q     (sda_q),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   spd_prom_link #(.ADDR_W(ADDR_W)) u_link (
      .clk       (clk),
      .rst_n     (rst_n),
      .sda_q     (sda_q),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .strap_i   (strap_i),
      .wp_i      (wp_i),
      .rd_data   (rd_data),
      .ptr       (ptr),
      .wr_req    (wr_req),
      .wr_ok     (wr_ok),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .drive_low (sda_drive_low),
      .state     (link_state)
   );

   // Preload wins over a bus write landing in the same cycle
   assign st_we   = preload_we | (wr_req & wr_ok);
   assign st_addr = preload_we ? preload_addr : wr_addr;
   assign st_data = preload_we ? preload_data : wr_data;

   spd_prom_store #(
      .ADDR_W      (ADDR_W),
      .CSUM_IDX    (CSUM_IDX),
      .RUNNING_SUM (RUNNING_SUM)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (st_we),
      .waddr   (st_addr),
      .wdata   (st_data),
      .raddr   (ptr),
      .rdata   (rd_data),
      .csum_ok (csum_ok)
   );

endmodule

// File: rtl/spd_prom_checker.sv
module spd_prom_checker
   import spd_prom_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input link_state_t       state,
   input logic              sda_drive_low,
   input logic              start_det,
   input logic              stop_det,
   input logic              wr_req,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              wp_i,
   input logic              preload_we,
   input logic              st_we,
   input logic              csum_ok
);

   // R2: idle slave never pulls the data line
   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_drive_low);

   // R9: stop brings the link back to idle with the line released
   a_r9_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (state == ST_IDLE && !sda_drive_low));

   // R8: any start restarts device address decoding
   a_r8_start_decode: assert property (@(posedge clk) disable iff (!rst_n)
      (start_det && !stop_det) |=> (state == ST_DEV));

   // R4: a protected write request never reaches the store
   a_r4_wp_guard: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && $past(wp_i) && !wr_addr[ADDR_W-1] && !preload_we) |-> !st_we);

   // R7: checksum status only moves after a store write
   a_r7_csum_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !st_we |=> $stable(csum_ok));

endmodule

bind spd_prom_slave spd_prom_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .state         (link_state),
   .sda_drive_low (sda_drive_low),
   .start_det     (start_det),
   .stop_det      (stop_det),
   .wr_req        (wr_req),
   .wr_addr       (wr_addr),
   .wp_i          (wp_i),
   .preload_we    (preload_we),
   .st_we         (st_we),
   .csum_ok       (csum_ok)
);

// File: tb/spd_prom_slave_tb.sv
module spd_prom_slave_tb;

   localparam int Q = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_line;
   logic       sda_drive_low;
   logic [2:0] strap = 3'b101;
   logic       wp = 1'b0;
   logic       pl_we = 1'b0;
   logic [7:0] pl_addr = 8'h00;
   logic [7:0] pl_data = 8'h00;
   logic       csum_ok;

   int n_chk = 0;
   int n_fail = 0;

   localparam logic [7:0] DEV_W = 8'hAA;
   localparam logic [7:0] DEV_R = 8'hAB;

   always #2.5 clk = ~clk;

   assign sda_line = sda_m & ~sda_drive_low;

   spd_prom_slave u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .scl_i         (scl_m),
      .sda_i         (sda_line),
      .sda_drive_low (sda_drive_low),
      .strap_i       (strap),
      .wp_i          (wp),
      .preload_we    (pl_we),
      .preload_addr  (pl_addr),
      .preload_data  (pl_data),
      .csum_ok       (csum_ok)
   );

   task automatic chk(input string tag, input int act, input int exp_v);
      n_chk++;
      if (act !== exp_v) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp_v);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wait_clk(Q);
      scl_m = 1'b1; wait_clk(Q);
      sda_m = 1'b0; wait_clk(Q);
      scl_m = 1'b0; wait_clk(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wait_clk(Q);
      scl_m = 1'b1; wait_clk(Q);
      sda_m = 1'b1; wait_clk(Q);
   endtask

   task automatic send_bit(input logic b);
      sda_m = b;    wait_clk(Q);
      scl_m = 1'b1; wait_clk(2 * Q);
      scl_m = 1'b0; wait_clk(Q);
   endtask

   task automatic read_bit(output logic b);
      sda_m = 1'b1; wait_clk(Q);
      scl_m = 1'b1; wait_clk(Q);
      b = sda_line; wait_clk(Q);
      scl_m = 1'b0; wait_clk(Q);
   endtask

   task automatic send_byte(input logic [7:0] v, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
      read_bit(b);
      ack = ~b;
   endtask

   task automatic recv_byte(output logic [7:0] v, input logic last);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         read_bit(b);
         v[i] = b;
      end
      send_bit(last);
   endtask

   task automatic write_bytes(input logic [7:0] a, input logic [7:0] d0,
                              input logic [7:0] d1, input int n, output logic all_ack);
      logic k;
      all_ack = 1'b1;
      bus_start();
      send_byte(DEV_W, k); all_ack &= k;
      send_byte(a, k);     all_ack &= k;
      send_byte(d0, k);    all_ack &= k;
      if (n > 1) begin
         send_byte(d1, k); all_ack &= k;
      end
      bus_stop();
      wait_clk(4);
   endtask

   task automatic read_one(input logic [7:0] a, output logic [7:0] v);
      logic k;
      bus_start();
      send_byte(DEV_W, k);
      send_byte(a, k);
      bus_start();
      send_byte(DEV_R, k);
      recv_byte(v, 1'b1);
      chk("R11 release after master nack", int'(sda_drive_low), 0);
      bus_stop();
      wait_clk(4);
   endtask

   task automatic t_reset();
      wait_clk(4);
      chk("R2 sda released after reset", int'(sda_drive_low), 0);
      chk("R7 checksum valid after reset", int'(csum_ok), 1);
   endtask

   task automatic t_address();
      logic k;
      bus_start();
      send_byte(8'hA6, k);
      chk("R1 wrong straps not acked", int'(k), 0);
      bus_stop();
      bus_start();
      send_byte(DEV_W, k);
      chk("R1 matching address acked", int'(k), 1);
      bus_stop();
      wait_clk(4);
   endtask

   task automatic t_defaults();
      logic [7:0] v;
      read_one(8'h00, v); chk("R2 byte0 default", int'(v), 'h80);
      read_one(8'h01, v); chk("R2 byte1 default", int'(v), 'h08);
      read_one(8'd63, v); chk("R2 checksum default", int'(v), 'h4B);
      read_one(8'd200, v); chk("R2 upper default", int'(v), 'hFF);
   endtask

   task automatic t_user_write();
      logic k;
      logic [7:0] v;
      wp = 1'b1;
      write_bytes(8'h90, 8'h5A, 8'h00, 1, k);
      chk("R5 upper write acked", int'(k), 1);
      read_one(8'h90, v); chk("R5 upper write under wp", int'(v), 'h5A);
      wp = 1'b0;
   endtask

   task automatic t_protect();
      logic k;
      logic [7:0] v;
      wp = 1'b1;
      write_bytes(8'h50, 8'h33, 8'h00, 1, k);
      chk("R4 protected write still acked", int'(k), 1);
      read_one(8'h50, v); chk("R4 protected write discarded", int'(v), 'hFF);
      wp = 1'b0;
      write_bytes(8'h50, 8'h33, 8'h00, 1, k);
      read_one(8'h50, v); chk("R4 unprotected write lands", int'(v), 'h33);
   endtask

   task automatic t_seq_wrap();
      logic k;
      logic [7:0] v0, v1, v2;
      write_bytes(8'hFE, 8'h11, 8'h22, 2, k);
      chk("R3 sequential write acked", int'(k), 1);
      bus_start();
      send_byte(DEV_W, k);
      send_byte(8'hFE, k);
      bus_start();
      send_byte(DEV_R, k);
      recv_byte(v0, 1'b0);
      recv_byte(v1, 1'b0);
      recv_byte(v2, 1'b1);
      bus_stop();
      wait_clk(4);
      chk("R3 first sequential byte", int'(v0), 'h11);
      chk("R3 second sequential byte", int'(v1), 'h22);
      chk("R6 read pointer wraps to 0", int'(v2), 'h80);
   endtask

   task automatic t_checksum();
      logic k;
      write_bytes(8'd5, 8'h00, 8'h00, 1, k);
      chk("R7 checksum broken by write", int'(csum_ok), 0);
      write_bytes(8'd63, 8'h4C, 8'h00, 1, k);
      chk("R7 checksum repaired", int'(csum_ok), 1);
   endtask

   task automatic t_preload();
      logic [7:0] v;
      wp = 1'b1;
      @(negedge clk);
      pl_we = 1'b1; pl_addr = 8'h20; pl_data = 8'h77;
      @(negedge clk);
      pl_we = 1'b0;
      wait_clk(2);
      chk("R7 checksum follows preload", int'(csum_ok), 0);
      read_one(8'h20, v); chk("R10 preload bypasses wp", int'(v), 'h77);
      wp = 1'b0;
   endtask

   task automatic t_restart();
      logic k;
      logic [7:0] v;
      bus_start();
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
      bus_start();
      send_byte(DEV_W, k);
      chk("R8 address after mid-byte start", int'(k), 1);
      send_byte(8'h90, k);
      bus_start();
      send_byte(DEV_R, k);
      recv_byte(v, 1'b1);
      bus_stop();
      wait_clk(4);
      chk("R8 read after restart", int'(v), 'h5A);
   endtask

   task automatic t_stop();
      logic k;
      bus_start();
      send_byte(DEV_W, k);
      bus_stop();
      send_byte(DEV_W, k);
      chk("R9 no ack without start", int'(k), 0);
      bus_stop();
      wait_clk(4);
   endtask

   initial begin
      wait_clk(5);
      rst_n = 1'b1;
      t_reset();
      t_address();
      t_defaults();
      t_user_write();
      t_protect();
      t_seq_wrap();
      t_checksum();
      t_preload();
      t_restart();
      t_stop();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule